// File: doc/BRIEF.md
# Enhanced parallel port host cycle sequencer

This block runs the host end of an enhanced parallel port transfer. A one-cycle request from the CPU side asks for a single byte, either an address or a data transfer, moving in either direction. The block sets the write line and the data direction, waits for the peripheral to show it is ready, then asserts the matching strobe. It adds wait states for as long as the peripheral holds its wait line low. The cycle ends when the peripheral releases that line, or when a programmable time-out expires.

Each request finishes with a single-cycle completion pulse and an error bit. Read data is returned on that pulse. A read that the port direction bit forbids is refused without touching the pins. The legacy control register can override the write line, and only the write line. A separate input drives the peripheral reset line.

Top module: `epp_host_seq`

## Requirements
- R1: An accepted request sets `n_write` to 0 for a write and to 1 for a read at the accepting edge. One clock later it asserts `n_addrstb` (when `req_addr`=1) or `n_datastb` (when `req_addr`=0) to 0. The two strobes are never 0 together.
- R2: The strobe is asserted only at an edge where `n_wait` is sampled 0. It stays at 0 at every edge where `n_wait` is sampled 0, unless the time-out expires.
- R3: At the first edge with the strobe active and `n_wait` sampled 1, the strobe returns to 1 and `done` pulses for one cycle with `err`=0. On a read, `rdata` holds the `pd_in` value sampled at that edge.
- R4: With `tmo_limit`=L and L nonzero, the strobe is released after exactly L active clocks whose `n_wait` samples were all 0. `done` then pulses with `err`=1, and `timeout_flag` becomes 1 at the same edge. The flag stays 1 until `clr_timeout` is sampled 1. L=0 disables the time-out.
- R5: A read requested while `pcd`=1 produces `done` with `err`=1 at the next edge. Neither strobe moves and `timeout_flag` is unchanged. Writes are unaffected by `pcd`.
- R6: For a write, `pd_oe`=1 and `pd_out`=`wdata` from the accepting edge until one clock after the strobe is released. At that edge `pd_oe` returns to 0 and `n_write` returns to 1. For a read, `pd_oe` stays 0.
- R7: While `spp_ovr_en` is sampled 1, `n_write` equals the sampled `spp_nwrite` one clock later. The strobes and data bus behave as without the override.
- R8: After reset both strobes, `n_write` and `n_reset` are 1, and `pd_oe`, `done` and `timeout_flag` are 0. `n_reset` equals the inverse of `port_rst` sampled one clock earlier.
- R9: A request raised while a cycle is in progress is ignored: it changes neither the running strobe nor `pd_out`, and it produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transfer (accepted when idle) |
| req_addr | input | 1 | 1: address transfer, 0: data transfer |
| req_write | input | 1 | 1: write, 0: read |
| wdata | input | DATA_W | Byte to write |
| rdata | output | DATA_W | Byte captured on a read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status, valid with done |
| tmo_limit | input | TMO_W | Wait-state limit in clocks, 0 disables |
| clr_timeout | input | 1 | Clears the sticky time-out flag |
| timeout_flag | output | 1 | Sticky time-out status |
| pcd | input | 1 | Port direction bit, reads only allowed at 0 |
| spp_ovr_en | input | 1 | Legacy control override of the write line |
| spp_nwrite | input | 1 | Override value of the write line |
| port_rst | input | 1 | Request to reset the peripheral |
| n_write | output | 1 | Active-low write indicator |
| n_datastb | output | 1 | Active-low data strobe |
| n_addrstb | output | 1 | Active-low address strobe |
| n_wait | input | 1 | Active-low peripheral wait / ready |
| n_reset | output | 1 | Active-low peripheral reset |
| pd_in | input | DATA_W | Port data bus, input side |
| pd_out | output | DATA_W | Port data bus, output side |
| pd_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with DATA_W=8 and TMO_W=6. With these values the largest time-out limit, 63, can be run to expiry in a short run. A zero-limit transfer held for 70 wait clocks goes past every count the counter could reach, which shows that the disabled time-out never fires. The limits 1, 5 and 63 cover the edges of the counter, and a release one clock before expiry covers the race between release and time-out.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_HOLD  = 2'd3
  } epp_state_e;
endpackage

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt;

  // counts wait clocks of the active strobe, saturating
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && cnt != CNT_MAX) begin
      cnt <= cnt + TMO_W'(1);
    end
  end

  // a zero limit disables expiry
  assign expire = (limit != '0) && (cnt == limit - TMO_W'(1));
endmodule

// File: rtl/epp_pin_ctl.sv
module epp_pin_ctl (
  input  logic clk,
  input  logic rst,
  input  logic nwrite_int,
  input  logic spp_ovr_en,
  input  logic spp_nwrite,
  input  logic port_rst,
  output logic n_write,
  output logic n_reset
);
  logic ovr_q;
  logic ovr_val_q;
  logic nres_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q     <= 1'b0;
      ovr_val_q <= 1'b1;
      nres_q    <= 1'b1;
    end else begin
      ovr_q     <= spp_ovr_en;
      ovr_val_q <= spp_nwrite;
      nres_q    <= ~port_rst;
    end
  end

  // only the write line may be taken over by the legacy control port
  assign n_write = ovr_q ? ovr_val_q : nwrite_int;
  assign n_reset = nres_q;
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pcd,
  input  logic              n_wait,
  input  logic [DATA_W-1:0] pd_in,
  input  logic              tmo_expire,
  input  logic              clr_timeout,
  output logic              timer_clr,
  output logic              timer_en,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              err,
  output logic              timeout_flag,
  output logic              nwrite_int,
  output logic              n_datastb,
  output logic              n_addrstb,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe
);
  epp_state_e state;
  logic       cur_addr;
  logic       cur_write;
  logic       tmo_hit;

  assign timer_clr = (state != ST_STRB);
  assign timer_en  = (state == ST_STRB) && !n_wait;
  assign tmo_hit   = (state == ST_STRB) && n_wait == 1'b0 && tmo_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= 1'b0;
      cur_write  <= 1'b0;
      rdata      <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      nwrite_int <= 1'b1;
      n_datastb  <= 1'b1;
      n_addrstb  <= 1'b1;
      pd_out     <= '0;
      pd_oe      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req) begin
            if (!req_write && pcd) begin
              // read forbidden by direction bit: refuse without a pin cycle
              done  <= 1'b1;
              err   <= 1'b1;
              state <= ST_HOLD;
            end else begin
              cur_addr   <= req_addr;
              cur_write  <= req_write;
              nwrite_int <= ~req_write;
              pd_oe      <= req_write;
              if (req_write) pd_out <= wdata;
              state      <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          // wait for the peripheral to signal ready
          if (!n_wait) begin
            if (cur_addr) n_addrstb <= 1'b0;
            else          n_datastb <= 1'b0;
            state <= ST_STRB;
          end
        end
        ST_STRB: begin
          if (n_wait) begin
            n_addrstb <= 1'b1;
            n_datastb <= 1'b1;
            if (!cur_write) rdata <= pd_in;
            done  <= 1'b1;
            err   <= 1'b0;
            state <= ST_HOLD;
          end else if (tmo_hit) begin
            n_addrstb <= 1'b1;
            n_datastb <= 1'b1;
            done  <= 1'b1;
            err   <= 1'b1;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          // bus turnaround: release drive and write line
          pd_oe      <= 1'b0;
          nwrite_int <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout_flag <= 1'b0;
    end else if (tmo_hit) begin
      timeout_flag <= 1'b1;
    end else if (clr_timeout) begin
      timeout_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/epp_host_seq.sv
module epp_host_seq #(
  parameter int DATA_W = 8,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              err,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              clr_timeout,
  output logic              timeout_flag,
  input  logic              pcd,
  input  logic              spp_ovr_en,
  input  logic              spp_nwrite,
  input  logic              port_rst,
  output logic              n_write,
  output logic              n_datastb,
  output logic              n_addrstb,
  input  logic              n_wait,
  output logic              n_reset,
  input  logic [DATA_W-1:0] pd_in,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe
);
  logic timer_clr;
  logic timer_en;
  logic tmo_expire;
  logic nwrite_int;

  epp_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (timer_clr),
    .en     (timer_en),
    .limit  (tmo_limit),
    .expire (tmo_expire)
  );

  epp_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .wdata        (wdata),
    .pcd          (pcd),
    .n_wait       (n_wait),
    .pd_in        (pd_in),
    .tmo_expire   (tmo_expire),
    .clr_timeout  (clr_timeout),
    .timer_clr    (timer_clr),
    .timer_en     (timer_en),
    .rdata        (rdata),
    .done         (done),
    .err          (err),
    .timeout_flag (timeout_flag),
    .nwrite_int   (nwrite_int),
    .n_datastb    (n_datastb),
    .n_addrstb    (n_addrstb),
    .pd_out       (pd_out),
    .pd_oe        (pd_oe)
  );

  epp_pin_ctl u_pins (
    .clk        (clk),
    .rst        (rst),
    .nwrite_int (nwrite_int),
    .spp_ovr_en (spp_ovr_en),
    .spp_nwrite (spp_nwrite),
    .port_rst   (port_rst),
    .n_write    (n_write),
    .n_reset    (n_reset)
  );
endmodule

// File: rtl/epp_host_seq_chk.sv
module epp_host_seq_chk (
  input logic clk,
  input logic rst,
  input logic n_datastb,
  input logic n_addrstb,
  input logic n_wait,
  input logic done,
  input logic pd_oe,
  input logic timeout_flag,
  input logic clr_timeout,
  input logic port_rst,
  input logic n_reset
);
  logic act;
  assign act = !n_datastb || !n_addrstb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!n_datastb && !n_addrstb)); // R1

  AST_STROBE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(act) |-> !$past(n_wait)); // R2

  AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (rst)
    ($past(act) && $past(n_wait)) |-> !act); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (timeout_flag && !clr_timeout) |=> timeout_flag); // R4

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(act) && pd_oe) |=> !pd_oe); // R6

  AST_NRESET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    port_rst |=> !n_reset); // R8
endmodule

bind epp_host_seq epp_host_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .n_datastb    (n_datastb),
  .n_addrstb    (n_addrstb),
  .n_wait       (n_wait),
  .done         (done),
  .pd_oe        (pd_oe),
  .timeout_flag (timeout_flag),
  .clr_timeout  (clr_timeout),
  .port_rst     (port_rst),
  .n_reset      (n_reset)
);

// File: tb/epp_host_seq_tb.sv
module epp_host_seq_tb;
  localparam int DATA_W = 8;
  localparam int TMO_W  = 6;

  typedef struct {
    logic [DATA_W-1:0] rd;
    logic              err;
    logic              chk_data;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst;
  logic              req, req_addr, req_write;
  logic [DATA_W-1:0] wdata, rdata, pd_in, pd_out;
  logic              done, err;
  logic [TMO_W-1:0]  tmo_limit;
  logic              clr_timeout, timeout_flag, pcd;
  logic              spp_ovr_en, spp_nwrite, port_rst;
  logic              n_write, n_datastb, n_addrstb, n_wait, n_reset, pd_oe;

  int   checks = 0;
  int   errors = 0;
  exp_t expq[$];

  always #4 clk = ~clk;

  epp_host_seq #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_write(req_write),
    .wdata(wdata), .rdata(rdata), .done(done), .err(err), .tmo_limit(tmo_limit),
    .clr_timeout(clr_timeout), .timeout_flag(timeout_flag), .pcd(pcd),
    .spp_ovr_en(spp_ovr_en), .spp_nwrite(spp_nwrite), .port_rst(port_rst),
    .n_write(n_write), .n_datastb(n_datastb), .n_addrstb(n_addrstb),
    .n_wait(n_wait), .n_reset(n_reset), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: every completion is compared with the scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(err == e.err, "R3/R4/R5 err on done", int'(err), int'(e.err));
        if (e.chk_data) check(rdata == e.rd, "R3 read data", int'(rdata), int'(e.rd));
      end
    end
  end

  // one transfer; wcyc wait clocks before release
  task automatic xfer(input bit a, input bit w, input logic [DATA_W-1:0] wd,
                      input logic [DATA_W-1:0] rv, input int wcyc, input bit poke);
    logic nw_exp;
    @(negedge clk);
    n_wait = 1'b0; pd_in = rv; req_addr = a; req_write = w; wdata = wd; req = 1'b1;
    expq.push_back('{rd: rv, err: 1'b0, chk_data: !w});
    @(negedge clk);
    req = 1'b0;
    nw_exp = spp_ovr_en ? spp_nwrite : !w;
    check(n_write == nw_exp, "R1/R7 n_write at accept", int'(n_write), int'(nw_exp));
    check(pd_oe == w, "R6 pd_oe at accept", int'(pd_oe), int'(w));
    check(n_datastb && n_addrstb, "R2 no strobe before ready edge", int'({n_addrstb, n_datastb}), 3);
    @(negedge clk);
    check(n_addrstb == !a && n_datastb == a, "R1 strobe select",
          int'({n_addrstb, n_datastb}), int'({!a, a}));
    if (w) check(pd_out == wd, "R6 pd_out driven", int'(pd_out), int'(wd));
    for (int i = 0; i < wcyc; i++) begin
      if (poke && i == 0) begin
        req = 1'b1; req_addr = !a; wdata = ~wd;
      end else begin
        req = 1'b0; req_addr = a;
      end
      @(negedge clk);
      check(n_addrstb == !a && n_datastb == a, "R2/R9 strobe held in wait",
            int'({n_addrstb, n_datastb}), int'({!a, a}));
      if (w) check(pd_out == wd, "R9 pd_out kept", int'(pd_out), int'(wd));
    end
    req = 1'b0;
    n_wait = 1'b1;
    @(negedge clk);
    check(n_datastb && n_addrstb, "R3 strobe released", int'({n_addrstb, n_datastb}), 3);
    check(done == 1'b1, "R3 done on release", int'(done), 1);
    check(pd_oe == w, "R6 pd_oe held one clock", int'(pd_oe), int'(w));
    @(negedge clk);
    nw_exp = spp_ovr_en ? spp_nwrite : 1'b1;
    check(pd_oe == 1'b0, "R6 pd_oe released", int'(pd_oe), 0);
    check(n_write == nw_exp, "R6 n_write restored", int'(n_write), int'(nw_exp));
  endtask

  task automatic tmo_xfer(input int lim);
    tmo_limit = TMO_W'(lim);
    @(negedge clk);
    n_wait = 1'b0; req_addr = 1'b0; req_write = 1'b0; req = 1'b1;
    expq.push_back('{rd: '0, err: 1'b1, chk_data: 1'b0});
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    check(n_datastb == 1'b0, "R4 strobe active", int'(n_datastb), 0);
    for (int i = 0; i < lim - 1; i++) begin
      @(negedge clk);
      check(n_datastb == 1'b0, "R4 strobe before limit", int'(n_datastb), 0);
    end
    @(negedge clk);
    check(n_datastb == 1'b1, "R4 strobe released at limit", int'(n_datastb), 1);
    check(done && err, "R4 done with err", int'({done, err}), 3);
    check(timeout_flag == 1'b1, "R4 flag set", int'(timeout_flag), 1);
    n_wait = 1'b1;
    repeat (3) @(negedge clk);
    check(timeout_flag == 1'b1, "R4 flag sticky", int'(timeout_flag), 1);
    clr_timeout = 1'b1;
    @(negedge clk);
    clr_timeout = 1'b0;
    check(timeout_flag == 1'b0, "R4 flag cleared", int'(timeout_flag), 0);
  endtask

  task automatic run_all();
    rst = 1'b1; req = 0; req_addr = 0; req_write = 0; wdata = '0; pd_in = '0;
    tmo_limit = TMO_W'(8); clr_timeout = 0; pcd = 0; spp_ovr_en = 0; spp_nwrite = 1;
    port_rst = 0; n_wait = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(n_datastb && n_addrstb && n_write, "R8 reset strobes/n_write",
          int'({n_datastb, n_addrstb, n_write}), 7);
    check(!pd_oe && !done && !timeout_flag, "R8 reset pd_oe/done/flag",
          int'({pd_oe, done, timeout_flag}), 0);
    check(n_reset == 1'b1, "R8 n_reset idle", int'(n_reset), 1);

    xfer(1'b0, 1'b1, 8'hA5, 8'h00, 0, 1'b0);   // data write, no wait
    xfer(1'b1, 1'b1, 8'h3C, 8'h00, 3, 1'b0);   // address write
    xfer(1'b0, 1'b0, 8'h00, 8'h5A, 2, 1'b0);   // data read
    xfer(1'b1, 1'b0, 8'h00, 8'hC3, 7, 1'b0);   // addr read, release one before limit 8
    xfer(1'b0, 1'b1, 8'h81, 8'h00, 4, 1'b1);   // R9 request poked mid-cycle

    tmo_xfer(5);
    tmo_xfer(1);
    tmo_xfer((1 << TMO_W) - 1);

    tmo_limit = '0;                              // R4 zero disables
    xfer(1'b0, 1'b0, 8'h00, 8'h77, 70, 1'b0);
    check(timeout_flag == 1'b0, "R4 zero limit never expires", int'(timeout_flag), 0);
    tmo_limit = TMO_W'(8);

    // R5 forbidden read
    pcd = 1'b1;
    @(negedge clk);
    req_write = 1'b0; req_addr = 1'b0; req = 1'b1;
    expq.push_back('{rd: '0, err: 1'b1, chk_data: 1'b0});
    @(negedge clk);
    req = 1'b0;
    check(done == 1'b1, "R5 refused read done", int'(done), 1);
    check(n_datastb && n_addrstb, "R5 no strobe", int'({n_addrstb, n_datastb}), 3);
    @(negedge clk);
    check(n_datastb && n_addrstb && !timeout_flag, "R5 pins and flag untouched",
          int'({n_addrstb, n_datastb, timeout_flag}), 6);
    xfer(1'b0, 1'b1, 8'h42, 8'h00, 1, 1'b0);   // R5 write allowed with pcd high
    pcd = 1'b0;

    // R7 override of the write line only
    @(negedge clk);
    spp_ovr_en = 1'b1; spp_nwrite = 1'b0;
    @(negedge clk);
    check(n_write == 1'b0, "R7 override applied", int'(n_write), 0);
    xfer(1'b1, 1'b0, 8'h00, 8'h99, 2, 1'b0);
    spp_ovr_en = 1'b0; spp_nwrite = 1'b1;
    @(negedge clk);
    check(n_write == 1'b1, "R7 override removed", int'(n_write), 1);

    // R8 peripheral reset output
    port_rst = 1'b1;
    @(negedge clk);
    check(n_reset == 1'b0, "R8 n_reset asserted", int'(n_reset), 0);
    port_rst = 1'b0;
    @(negedge clk);
    check(n_reset == 1'b1, "R8 n_reset released", int'(n_reset), 1);

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R9 all completions seen once", expq.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule